// File: doc/BRIEF.md
# Per-Core Tick and Interval Timer

This block is one local timer of the sort placed beside each processor core. It counts in two stages. A tick prescaler divides the input clock by a programmed tick count plus one. Each tick it produces steps an interval counter down from a programmed interrupt count. When that counter runs out, an interrupt status flag is set. An enable bit gates that flag onto the interrupt line.

Software reaches the block through a simple 32-bit register write and read port. Writes do not take effect on the cycle they are issued. They travel through a short fixed-latency pipeline. When a write to a tick count buffer, an interrupt count buffer or a control register lands, a sticky write-acknowledge bit is set. Software can poll that bit and then clear it by writing one.

The interrupt count buffer only accepts a new value when the write carries an update flag in its top bit. The control register chooses between two modes. In one-shot mode the timer fires a single time. In repeating interval mode it reloads and fires again on its own.

Top module: `core_tick_timer`

## Requirements
- R1: After reset every readable register (offsets 0x00, 0x08, 0x20, 0x30, 0x34, 0x40) reads 0 and `irq_o` is low.
- R2: A write sampled at clock edge E takes effect at edge E+3. At the same edge it sets its write-acknowledge bit at offset 0x40: bit 0 for a write to the tick count buffer (0x00), bit 1 for the interrupt count buffer (0x08), bit 3 for control (0x20). Writes to other offsets set no acknowledge bit. Writing 1 to an acknowledge bit at 0x40 clears it.
- R3: A write to 0x08 loads its low 31 bits into the interrupt count buffer only when bit 31 is 1. When bit 31 is 0, the stored count is unchanged.
- R4: With control bit 0 (tick run) set and tick count N at 0x00, a tick occurs every N+1 clocks. The first tick comes N+1 clocks after the control write takes effect.
- R5: With control bits 0 and 1 set and bit 2 clear (one-shot), the interval counter expires on the C-th tick for a count C of 1 or more. A count of 0 behaves as 1. After expiry it never expires again until bit 1 is cleared and set again.
- R6: With control bit 2 set (interval mode), the counter reloads from the count buffer on each expiry. It then keeps expiring every C×(N+1) clocks.
- R7: Interrupt status bit 0 at 0x30 is set on expiry. Writing 1 to it clears it. Writing 0 leaves it unchanged.
- R8: `irq_o` goes high one clock after status bit 0 and interrupt enable bit 0 (0x34) are both 1. It stays low whenever the enable is 0.
- R9: Clearing the start bits halts both counters, so no expiry occurs. Starting again counts the full period from the buffered values.
- R10: `rd_data` returns, one clock after `rd_addr` is presented, the register at that offset; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The hardest state to reach from the ports is a halt in the middle of a period followed by a restart. The stop write must land before the pending expiry, despite the three-cycle write latency. The stimulus does this by choosing a long period (tick count 3, interrupt count 5). It then issues the stop a known number of cycles after the start. After that it watches the interrupt line for well beyond one period, and times the restart against the full period. The repeating mode is timed the same way, from one rising edge of the interrupt line to the next, with a status clear in between.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam int BUS_W   = 32;
  localparam int OFS_W   = 8;

  localparam logic [OFS_W-1:0] OFS_TICKBUF = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CNTBUF  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 8'h30;
  localparam logic [OFS_W-1:0] OFS_ENABLE  = 8'h34;
  localparam logic [OFS_W-1:0] OFS_ACK     = 8'h40;

  localparam int CTRL_TICK_RUN = 0;
  localparam int CTRL_INT_RUN  = 1;
  localparam int CTRL_REPEAT   = 2;
  localparam int CTRL_W        = 3;

  localparam int ACK_TICKBUF = 0;
  localparam int ACK_CNTBUF  = 1;
  localparam int ACK_CTRL    = 3;
  localparam int ACK_W       = 4;

  localparam int UPDATE_BIT  = 31;

  typedef struct packed {
    logic             vld;
    logic [OFS_W-1:0] ofs;
    logic [BUS_W-1:0] dat;
  } wr_req_t;
endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [OFS_W-1:0]  rd_addr,
  input  logic              expire,
  output logic [BUS_W-1:0]  rd_data,
  output logic              irq_o,
  output logic [TICK_W-1:0] tick_buf,
  output logic [CNT_W-1:0]  cnt_buf,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int LAST = WR_LAT - 1;

  wr_req_t            pipe [WR_LAT];
  wr_req_t            land;
  logic               hit_tick, hit_cnt, hit_ctrl, hit_stat, hit_en, hit_ack;
  logic               status, enable;
  logic [ACK_W-1:0]   ack, ack_set, ack_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WR_LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= '{vld: wr_en, ofs: wr_addr, dat: wr_data};
      for (int i = 1; i < WR_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign land     = pipe[LAST];
  assign hit_tick = land.vld && land.ofs == OFS_TICKBUF;
  assign hit_cnt  = land.vld && land.ofs == OFS_CNTBUF;
  assign hit_ctrl = land.vld && land.ofs == OFS_CTRL;
  assign hit_stat = land.vld && land.ofs == OFS_STATUS;
  assign hit_en   = land.vld && land.ofs == OFS_ENABLE;
  assign hit_ack  = land.vld && land.ofs == OFS_ACK;

  always_comb begin
    ack_set = '0;
    ack_set[ACK_TICKBUF] = hit_tick;
    ack_set[ACK_CNTBUF]  = hit_cnt;
    ack_set[ACK_CTRL]    = hit_ctrl;
    ack_clr = hit_ack ? land.dat[ACK_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_buf <= '0;
      cnt_buf  <= '0;
      ctrl     <= '0;
      enable   <= 1'b0;
      status   <= 1'b0;
      ack      <= '0;
      irq_o    <= 1'b0;
    end else begin
      if (hit_tick) tick_buf <= land.dat[TICK_W-1:0];
      if (hit_cnt && land.dat[UPDATE_BIT]) cnt_buf <= land.dat[CNT_W-1:0];
      if (hit_ctrl) ctrl <= land.dat[CTRL_W-1:0];
      if (hit_en) enable <= land.dat[0];
      status <= expire | (status & ~(hit_stat & land.dat[0]));
      ack    <= (ack & ~ack_clr) | ack_set;
      irq_o  <= status & enable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        OFS_TICKBUF: rd_data <= BUS_W'(tick_buf);
        OFS_CNTBUF:  rd_data <= BUS_W'(cnt_buf);
        OFS_CTRL:    rd_data <= BUS_W'(ctrl);
        OFS_STATUS:  rd_data <= BUS_W'(status);
        OFS_ENABLE:  rd_data <= BUS_W'(enable);
        OFS_ACK:     rd_data <= BUS_W'(ack);
        default:     rd_data <= '0;
      endcase
    end
  end

  // R2: a landed control write leaves its acknowledge bit set
  a_r2_ctrl_ack: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl |=> ack[ACK_CTRL]);

  // R3: a count write without the update flag keeps the buffer
  a_r3_no_flag_keep: assert property (@(posedge clk) disable iff (rst)
    (hit_cnt && !land.dat[UPDATE_BIT]) |=> $stable(cnt_buf));

  // R7: an expiry always leaves the status flag set
  a_r7_status_set: assert property (@(posedge clk) disable iff (rst)
    expire |=> status);

  // R8: status with enable drives the interrupt line next cycle
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    (status && enable) |=> irq_o);
endmodule

// File: rtl/ctt_counters.sv
module ctt_counters
  import ctt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] tick_buf,
  input  logic [CNT_W-1:0]  cnt_buf,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              expire
);
  logic [TICK_W-1:0] pcnt;
  logic [CNT_W-1:0]  icnt;
  logic              done;
  logic              tick_run, int_run, repeat_md, tick, last;

  assign tick_run  = ctrl[CTRL_TICK_RUN];
  assign int_run   = ctrl[CTRL_INT_RUN];
  assign repeat_md = ctrl[CTRL_REPEAT];
  assign tick      = tick_run && (pcnt >= tick_buf);
  assign last      = icnt <= CNT_W'(1);
  assign expire    = int_run && !done && tick && last;

  always_ff @(posedge clk) begin
    if (rst || !tick_run) pcnt <= '0;
    else if (tick)        pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt <= '0;
      done <= 1'b0;
    end else if (!int_run) begin
      icnt <= cnt_buf;
      done <= 1'b0;
    end else if (tick && !done) begin
      if (last) begin
        icnt <= repeat_md ? cnt_buf : '0;
        done <= !repeat_md;
      end else begin
        icnt <= icnt - 1'b1;
      end
    end
  end

  // R4: with a stable divisor the prescaler never passes its limit
  a_r4_pcnt_bound: assert property (@(posedge clk) disable iff (rst)
    (tick_run && $past(tick_run) && $stable(tick_buf)) |-> pcnt <= tick_buf);

  // R5: a finished one-shot raises no further expiry
  a_r5_single_shot: assert property (@(posedge clk) disable iff (rst)
    done |-> !expire);

  // R6: interval mode reloads the buffered count on expiry
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (expire && repeat_md) |=> icnt == $past(cnt_buf));

  // R9: a stopped prescaler sits at zero
  a_r9_halt_clear: assert property (@(posedge clk) disable iff (rst)
    !tick_run |=> pcnt == '0);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31,
  parameter int WR_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [OFS_W-1:0] rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_o
);
  logic [TICK_W-1:0] tick_buf;
  logic [CNT_W-1:0]  cnt_buf;
  logic [CTRL_W-1:0] ctrl;
  logic              expire;

  ctt_regs #(.TICK_W(TICK_W), .CNT_W(CNT_W), .WR_LAT(WR_LAT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .expire(expire), .rd_data(rd_data), .irq_o(irq_o),
    .tick_buf(tick_buf), .cnt_buf(cnt_buf), .ctrl(ctrl)
  );

  ctt_counters #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_buf(tick_buf), .cnt_buf(cnt_buf),
    .ctrl(ctrl), .expire(expire)
  );
endmodule

// File: tb/tb_core_tick_timer.sv
`timescale 1ns/1ps
module tb_core_tick_timer;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  core_tick_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk);
    @(negedge clk); d = rd_data;
  endtask

  // edges after the last write's sampling edge until irq_o reads lvl
  task automatic wait_irq(input logic lvl, output int k);
    k = 0;
    while (k < 3000) begin
      @(posedge clk); @(negedge clk); k++;
      if (irq_o === lvl) break;
    end
  endtask

  task automatic quiet(input int n, output logic seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_o !== 1'b0) seen = 1;
    end
  endtask

  task automatic disarm();
    bus_wr(8'h20, 0);
    bus_wr(8'h30, 1);
    bus_wr(8'h40, 32'hF);
    settle();
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic seen;
    int k, per, tprev;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 0);
    rd_reg(8'h00, v); check("R1 tickbuf", v, 0);
    rd_reg(8'h08, v); check("R1 cntbuf", v, 0);
    rd_reg(8'h20, v); check("R1 ctrl", v, 0);
    rd_reg(8'h30, v); check("R1 status", v, 0);
    rd_reg(8'h34, v); check("R1 enable", v, 0);
    rd_reg(8'h40, v); check("R1 ack", v, 0);

    // R2 latency of a tick buffer write and its ack bit
    @(negedge clk); rd_addr = 8'h40;
    bus_wr(8'h00, 2);
    repeat (3) @(posedge clk);
    @(negedge clk); check("R2 ack before landing", rd_data, 0);
    @(posedge clk); @(negedge clk); check("R2 ack on landing", rd_data, 1);
    bus_wr(8'h40, 1); settle();
    rd_reg(8'h40, v); check("R2 ack cleared", v, 0);
    bus_wr(8'h34, 1); settle();
    rd_reg(8'h40, v); check("R2 enable write no ack", v, 0);
    bus_wr(8'h20, 0); settle();
    rd_reg(8'h40, v); check("R2 ctrl ack", v, 32'h8);
    bus_wr(8'h08, 32'h8000_0004); settle();
    rd_reg(8'h40, v); check("R2 cntbuf ack", v, 32'hA);
    bus_wr(8'h40, 32'hF); settle();

    // R3 update flag
    rd_reg(8'h08, v); check("R3 flagged load", v, 4);
    bus_wr(8'h08, 32'h0000_0007); settle();
    rd_reg(8'h08, v); check("R3 no-flag ignored", v, 4);
    rd_reg(8'h40, v); check("R2 no-flag still acked", v, 32'h2);

    // R10 readback map
    rd_reg(8'h00, v); check("R10 tickbuf readback", v, 2);
    rd_reg(8'h04, v); check("R10 unmapped", v, 0);
    rd_reg(8'h34, v); check("R10 enable readback", v, 1);

    // R4 and R5: one-shot sweep over tick count and interrupt count
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < 4; c++) begin
        disarm();
        bus_wr(8'h00, n);
        bus_wr(8'h08, 32'h8000_0000 | c);
        settle();
        bus_wr(8'h20, 3);
        wait_irq(1, k);
        per = ((c == 0) ? 1 : c) * (n + 1);
        check($sformatf("R5 one-shot n=%0d c=%0d", n, c), k, 4 + per);
        rd_reg(8'h30, v); check("R7 status set", v, 1);
        bus_wr(8'h30, 1);
        wait_irq(0, k);
        quiet(3 * per + 12, seen);
        check("R5 no second expiry", {31'b0, seen}, 0);
        rd_reg(8'h30, v); check("R5 status stays clear", v, 0);
      end
    end

    // R6 interval mode: period c*(n+1) = 9
    disarm();
    bus_wr(8'h00, 2);
    bus_wr(8'h08, 32'h8000_0003);
    settle();
    bus_wr(8'h20, 7);
    wait_irq(1, k);
    check("R6 first interval", k, 13);
    tprev = cyc;
    for (int i = 0; i < 3; i++) begin
      bus_wr(8'h30, 1);
      wait_irq(0, k);
      wait_irq(1, k);
      check($sformatf("R6 repeat period %0d", i), cyc - tprev, 9);
      tprev = cyc;
    end

    // R8 enable gating, R7 write of 0 keeps status
    disarm();
    bus_wr(8'h34, 0);
    bus_wr(8'h00, 1);
    bus_wr(8'h08, 32'h8000_0002);
    settle();
    bus_wr(8'h20, 3);
    quiet(30, seen);
    check("R8 gated irq low", {31'b0, seen}, 0);
    rd_reg(8'h30, v); check("R7 status set while gated", v, 1);
    bus_wr(8'h30, 0); settle();
    rd_reg(8'h30, v); check("R7 write 0 keeps status", v, 1);
    bus_wr(8'h34, 1);
    wait_irq(1, k);
    check("R8 irq after enable", k, 4);
    bus_wr(8'h30, 1);
    wait_irq(0, k);
    check("R7 irq drop after clear", k, 4);

    // R9 halt mid-period, restart from full period 20
    disarm();
    bus_wr(8'h00, 3);
    bus_wr(8'h08, 32'h8000_0005);
    settle();
    bus_wr(8'h20, 7);
    repeat (12) @(posedge clk);
    bus_wr(8'h20, 0);
    quiet(60, seen);
    check("R9 halted no irq", {31'b0, seen}, 0);
    rd_reg(8'h30, v); check("R9 halted no status", v, 0);
    bus_wr(8'h20, 7);
    wait_irq(1, k);
    check("R9 restart full period", k, 24);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule